// File: doc/BRIEF.md
# Boot Region Remap Decoder

This block steers a 32-bit request address to exactly one slave select (boot ROM, on-chip RAM, SDRAM, bridge window A or bridge window B), or it flags a decode error. It is purely combinational from the address, the requester class and a small control register. The processor side and all other masters each see their own mapping of address 0. The processor side can put either the boot ROM or the on-chip RAM at the bottom of its map. Every other master can put either SDRAM or the on-chip RAM there.

Two high aliases never move: the boot ROM is always at 0xFFFD_0000 and the on-chip RAM is always at 0xFFFF_0000. The two bridge windows are each gated by a visibility bit. An access to a hidden window ends in a decode error. The control register can only be written. Every write replaces the whole register, and the block offers no path to read it back. Software therefore has to keep its own copy of the settings.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset the control register holds all zeros. In that state the processor sees the boot ROM at address 0, other masters see SDRAM at address 0, and both bridge windows are hidden.
- R2: For a processor request below 64 KiB, control bit 0 selects the slave: 0 selects the boot ROM (slave_sel = 5'b00001) and 1 selects the on-chip RAM (slave_sel = 5'b00010).
- R3: For a non-processor request below 1 MiB, control bit 1 selects the slave. With bit 1 at 0, every address below 1 MiB goes to SDRAM (slave_sel = 5'b00100). With bit 1 at 1, addresses below 64 KiB go to the on-chip RAM.
- R4: An address from 64 KiB up to but not including 1 MiB gives dec_err = 1 and slave_sel = 0 whenever the requester's low region holds a 64 KiB memory. This is always the case for the processor, and for other masters when bit 1 is 1.
- R5: Addresses from 1 MiB up to 0xBFFF_FFFF select SDRAM for both requester classes, whatever the control bits hold.
- R6: 0xFFFD_0000 to 0xFFFD_FFFF always selects the boot ROM, and 0xFFFF_0000 to 0xFFFF_FFFF always selects the on-chip RAM, for both classes and any control value.
- R7: Window A is 0xC000_0000 to 0xDFFF_FFFF. With control bit 2 at 1 it selects slave_sel = 5'b01000; with bit 2 at 0 it gives a decode error.
- R8: Window B is 0xFF20_0000 to 0xFF3F_FFFF. With control bit 3 at 1 it selects slave_sel = 5'b10000; with bit 3 at 0 it gives a decode error.
- R9: Any other address at or above 0xC000_0000 gives a decode error.
- R10: When cfg_wr_en is high at a rising clock edge, cfg_wr_data replaces all four control bits from the next cycle on. Bits not set in the write are cleared, not kept. Without a write the register holds its value.
- R11: In every case exactly one of the following is true: one slave_sel bit is set, or dec_err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wr_data | input | 4 | New control value: bit0 processor low = on-chip RAM, bit1 others low = on-chip RAM, bit2 window A visible, bit3 window B visible |
| req_addr | input | 32 | Request address |
| req_is_cpu | input | 1 | 1 for a processor-side request, 0 for any other master |
| slave_sel | output | 5 | One-hot select: bit0 boot ROM, bit1 on-chip RAM, bit2 SDRAM, bit3 window A, bit4 window B |
| dec_err | output | 1 | Decode error; slave_sel is zero when set |

## Verification
The hardest case to reach is the hole from 64 KiB to 1 MiB for non-processor masters. It only exists once bit 1 has been written, and a write-only register gives no port from which to see that the write landed. The stimulus therefore keeps its own copy of the control word and sweeps the hole edges (0x1_0000 and 0xF_FFFF) for both classes, both before and after the write. It also checks the cycle in which the write is still pending, and then a second write that omits an earlier bit, to show that nothing of the old value survives.

// File: rtl/brr_pkg.sv
package brr_pkg;

    localparam int NUM_SLAVES = 5;

    typedef enum logic [2:0] {
        SLV_ROM   = 3'd0,
        SLV_OCRAM = 3'd1,
        SLV_SDRAM = 3'd2,
        SLV_WINA  = 3'd3,
        SLV_WINB  = 3'd4
    } slave_e;

    // Bit order matches cfg_wr_data: bit0 at the bottom
    typedef struct packed {
        logic winb_vis;
        logic wina_vis;
        logic other_low_ocram;
        logic cpu_low_ocram;
    } remap_ctrl_t;

    localparam int CTRL_W = $bits(remap_ctrl_t);
    localparam remap_ctrl_t CTRL_RESET = '0;

    typedef struct packed {
        logic   err;
        slave_e slv;
    } route_t;

endpackage

// File: rtl/brr_ctrl_reg.sv
module brr_ctrl_reg
    import brr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output remap_ctrl_t       ctrl_q
);

    remap_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = remap_ctrl_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R10: a write replaces every bit
    p_write_whole_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == remap_ctrl_t'($past(wr_data))));

    // R10: no write, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/brr_low_decode.sv
module brr_low_decode
    import brr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SMALL_LOG2 = 16,
    parameter int LOW_LOG2   = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_cpu,
    input  logic              cpu_low_ocram,
    input  logic              other_low_ocram,
    output route_t            route
);

    localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] SMALL_TOP = ONE << SMALL_LOG2;
    localparam logic [ADDR_W-1:0] LOW_TOP   = ONE << LOW_LOG2;

    logic   small_mem_d;
    slave_e low_target_d;

    always_comb begin
        // Which 64 KiB memory, if any, sits at address 0 for this class
        small_mem_d  = is_cpu | other_low_ocram;
        low_target_d = SLV_OCRAM;
        if (is_cpu && !cpu_low_ocram) begin
            low_target_d = SLV_ROM;
        end

        route.err = 1'b0;
        route.slv = SLV_SDRAM;
        if (addr < LOW_TOP && small_mem_d) begin
            if (addr < SMALL_TOP) begin
                route.slv = low_target_d;
            end else begin
                route.err = 1'b1;
            end
        end
    end

endmodule

// File: rtl/brr_high_decode.sv
module brr_high_decode
    import brr_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                ALIAS_LOG2  = 16,
    parameter logic [ADDR_W-1:0] ROM_ALIAS   = 32'hFFFD_0000,
    parameter logic [ADDR_W-1:0] OCRAM_ALIAS = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] WINA_BASE   = 32'hC000_0000,
    parameter int                WINA_LOG2   = 29,
    parameter logic [ADDR_W-1:0] WINB_BASE   = 32'hFF20_0000,
    parameter int                WINB_LOG2   = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wina_vis,
    input  logic              winb_vis,
    output route_t            route
);

    logic hit_rom_d, hit_ocram_d, hit_wina_d, hit_winb_d;

    always_comb begin
        hit_rom_d   = (addr >> ALIAS_LOG2) == (ROM_ALIAS   >> ALIAS_LOG2);
        hit_ocram_d = (addr >> ALIAS_LOG2) == (OCRAM_ALIAS >> ALIAS_LOG2);
        hit_wina_d  = (addr >> WINA_LOG2)  == (WINA_BASE   >> WINA_LOG2);
        hit_winb_d  = (addr >> WINB_LOG2)  == (WINB_BASE   >> WINB_LOG2);

        route.err = 1'b1;
        route.slv = SLV_SDRAM;
        if (hit_rom_d) begin
            route.err = 1'b0;
            route.slv = SLV_ROM;
        end else if (hit_ocram_d) begin
            route.err = 1'b0;
            route.slv = SLV_OCRAM;
        end else if (hit_wina_d) begin
            route.err = !wina_vis;
            route.slv = SLV_WINA;
        end else if (hit_winb_d) begin
            route.err = !winb_vis;
            route.slv = SLV_WINB;
        end
    end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import brr_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                SMALL_LOG2  = 16,
    parameter int                LOW_LOG2    = 20,
    parameter logic [ADDR_W-1:0] SDRAM_TOP   = 32'hC000_0000,
    parameter logic [ADDR_W-1:0] ROM_ALIAS   = 32'hFFFD_0000,
    parameter logic [ADDR_W-1:0] OCRAM_ALIAS = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] WINA_BASE   = 32'hC000_0000,
    parameter int                WINA_LOG2   = 29,
    parameter logic [ADDR_W-1:0] WINB_BASE   = 32'hFF20_0000,
    parameter int                WINB_LOG2   = 21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [CTRL_W-1:0]     cfg_wr_data,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_is_cpu,
    output logic [NUM_SLAVES-1:0] slave_sel,
    output logic                  dec_err
);

    localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] SMALL_TOP = ONE << SMALL_LOG2;
    localparam logic [ADDR_W-1:0] LOW_TOP   = ONE << LOW_LOG2;

    remap_ctrl_t ctrl_q;
    route_t      low_route, high_route, pick_d;

    brr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .ctrl_q  (ctrl_q)
    );

    brr_low_decode #(
        .ADDR_W     (ADDR_W),
        .SMALL_LOG2 (SMALL_LOG2),
        .LOW_LOG2   (LOW_LOG2)
    ) u_low (
        .addr            (req_addr),
        .is_cpu          (req_is_cpu),
        .cpu_low_ocram   (ctrl_q.cpu_low_ocram),
        .other_low_ocram (ctrl_q.other_low_ocram),
        .route           (low_route)
    );

    brr_high_decode #(
        .ADDR_W      (ADDR_W),
        .ALIAS_LOG2  (SMALL_LOG2),
        .ROM_ALIAS   (ROM_ALIAS),
        .OCRAM_ALIAS (OCRAM_ALIAS),
        .WINA_BASE   (WINA_BASE),
        .WINA_LOG2   (WINA_LOG2),
        .WINB_BASE   (WINB_BASE),
        .WINB_LOG2   (WINB_LOG2)
    ) u_high (
        .addr     (req_addr),
        .wina_vis (ctrl_q.wina_vis),
        .winb_vis (ctrl_q.winb_vis),
        .route    (high_route)
    );

    always_comb begin
        pick_d = (req_addr < SDRAM_TOP) ? low_route : high_route;
    end

    assign dec_err = pick_d.err;

    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_sel
        localparam slave_e IDX = slave_e'(i);
        assign slave_sel[i] = !pick_d.err && (pick_d.slv == IDX);
    end

    localparam logic [NUM_SLAVES-1:0] SEL_ROM   = 5'b00001;
    localparam logic [NUM_SLAVES-1:0] SEL_OCRAM = 5'b00010;
    localparam logic [NUM_SLAVES-1:0] SEL_SDRAM = 5'b00100;

    // R11: a select or an error, never both, never neither
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({slave_sel, dec_err}) == 1);

    // R5: middle range is SDRAM regardless of class and control
    p_sdram_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr >= LOW_TOP && req_addr < SDRAM_TOP) |-> slave_sel == SEL_SDRAM);

    // R6: fixed aliases never move
    p_rom_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_addr >> SMALL_LOG2) == (ROM_ALIAS >> SMALL_LOG2)) |-> slave_sel == SEL_ROM);
    p_ocram_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_addr >> SMALL_LOG2) == (OCRAM_ALIAS >> SMALL_LOG2)) |-> slave_sel == SEL_OCRAM);

    // R4: hole above a 64 KiB low memory
    p_low_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr >= SMALL_TOP && req_addr < LOW_TOP
         && (req_is_cpu || ctrl_q.other_low_ocram)) |-> dec_err);

    // R7: hidden window A errors
    p_hidden_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((req_addr >> WINA_LOG2) == (WINA_BASE >> WINA_LOG2)) && !ctrl_q.wina_vis) |-> dec_err);

    // R8: hidden window B errors
    p_hidden_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((req_addr >> WINB_LOG2) == (WINB_BASE >> WINB_LOG2)) && !ctrl_q.winb_vis) |-> dec_err);

endmodule

// File: tb/boot_remap_decoder_test.sv
module boot_remap_decoder_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] S_ROM = 5'b00001;
    localparam logic [4:0] S_OCR = 5'b00010;
    localparam logic [4:0] S_SDR = 5'b00100;
    localparam logic [4:0] S_WA  = 5'b01000;
    localparam logic [4:0] S_WB  = 5'b10000;
    localparam logic [4:0] S_NON = 5'b00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_data = '0;
    logic [31:0] req_addr = '0;
    logic        req_is_cpu = 1'b0;
    logic [4:0]  slave_sel;
    logic        dec_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    boot_remap_decoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .req_addr    (req_addr),
        .req_is_cpu  (req_is_cpu),
        .slave_sel   (slave_sel),
        .dec_err     (dec_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] a, input logic cpu,
                         input logic [4:0] exp_sel, input logic exp_err,
                         input string req);
        req_addr   = a;
        req_is_cpu = cpu;
        #1;
        checks++;
        if (slave_sel !== exp_sel || dec_err !== exp_err) begin
            failures++;
            $display("FAIL %s addr=%h cpu=%0b actual sel=%b err=%b expected sel=%b err=%b",
                     req, a, cpu, slave_sel, dec_err, exp_sel, exp_err);
        end
        checks++;
        if ($countones({slave_sel, dec_err}) != 1) begin
            failures++;
            $display("FAIL R11 addr=%h actual sel=%b err=%b expected exactly one outcome",
                     a, slave_sel, dec_err);
        end
    endtask

    task automatic write_ctrl(input logic [3:0] v);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic t_reset_r1;
        check(32'h0000_1000, 1'b1, S_ROM, 1'b0, "R1 cpu low");
        check(32'h0000_1000, 1'b0, S_SDR, 1'b0, "R1 other low");
        check(32'hC000_0010, 1'b0, S_NON, 1'b1, "R1 window A hidden");
        check(32'hFF20_0000, 1'b1, S_NON, 1'b1, "R1 window B hidden");
    endtask

    task automatic t_cpu_low_r2;
        write_ctrl(4'b0001);
        check(32'h0000_0000, 1'b1, S_OCR, 1'b0, "R2 cpu 0 ocram");
        check(32'h0000_FFFF, 1'b1, S_OCR, 1'b0, "R2 cpu top ocram");
        check(32'h0000_0100, 1'b0, S_SDR, 1'b0, "R2 other unaffected");
        write_ctrl(4'b0000);
        check(32'h0000_FFFF, 1'b1, S_ROM, 1'b0, "R2 cpu back to rom");
    endtask

    task automatic t_other_low_r3;
        check(32'h0008_0000, 1'b0, S_SDR, 1'b0, "R3 other whole low sdram");
        write_ctrl(4'b0010);
        check(32'h0000_0020, 1'b0, S_OCR, 1'b0, "R3 other ocram");
        check(32'h0000_0020, 1'b1, S_ROM, 1'b0, "R3 cpu unaffected");
    endtask

    task automatic t_hole_r4;
        // control still 0010
        check(32'h0001_0000, 1'b1, S_NON, 1'b1, "R4 cpu hole bottom");
        check(32'h0001_0000, 1'b0, S_NON, 1'b1, "R4 other hole bottom");
        check(32'h000F_FFFF, 1'b0, S_NON, 1'b1, "R4 other hole top");
        write_ctrl(4'b0000);
        check(32'h0001_0000, 1'b0, S_SDR, 1'b0, "R4 no hole with sdram");
        check(32'h000F_FFFF, 1'b1, S_NON, 1'b1, "R4 cpu hole top");
    endtask

    task automatic t_sdram_r5;
        write_ctrl(4'b1111);
        check(32'h0010_0000, 1'b1, S_SDR, 1'b0, "R5 cpu 1MiB");
        check(32'h0010_0000, 1'b0, S_SDR, 1'b0, "R5 other 1MiB");
        check(32'hBFFF_FFFF, 1'b1, S_SDR, 1'b0, "R5 top of sdram");
    endtask

    task automatic t_alias_r6;
        for (int k = 0; k < 2; k++) begin
            write_ctrl(k == 0 ? 4'b0000 : 4'b0011);
            check(32'hFFFD_0004, 1'b1, S_ROM, 1'b0, "R6 rom alias cpu");
            check(32'hFFFD_FFFF, 1'b0, S_ROM, 1'b0, "R6 rom alias other");
            check(32'hFFFF_FFFC, 1'b0, S_OCR, 1'b0, "R6 ocram alias other");
            check(32'hFFFF_0000, 1'b1, S_OCR, 1'b0, "R6 ocram alias cpu");
        end
    endtask

    task automatic t_windows_r7_r8;
        write_ctrl(4'b0100);
        check(32'hC000_0000, 1'b1, S_WA,  1'b0, "R7 window A bottom");
        check(32'hDFFF_FFFF, 1'b0, S_WA,  1'b0, "R7 window A top");
        check(32'hFF20_0000, 1'b0, S_NON, 1'b1, "R8 window B hidden");
        write_ctrl(4'b1000);
        check(32'hFF3F_FFFF, 1'b1, S_WB,  1'b0, "R8 window B top");
        check(32'hFF20_0000, 1'b0, S_WB,  1'b0, "R8 window B bottom");
        check(32'hC000_0000, 1'b1, S_NON, 1'b1, "R7 window A hidden again");
    endtask

    task automatic t_unmapped_r9;
        write_ctrl(4'b1111);
        check(32'hE000_0000, 1'b1, S_NON, 1'b1, "R9 above window A");
        check(32'hFF40_0000, 1'b0, S_NON, 1'b1, "R9 above window B");
        check(32'hFFFC_FFFF, 1'b1, S_NON, 1'b1, "R9 below rom alias");
        check(32'hFFFE_0000, 1'b0, S_NON, 1'b1, "R9 between aliases");
    endtask

    task automatic t_write_r10;
        write_ctrl(4'b0000);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = 4'b0001;
        check(32'h0000_0000, 1'b1, S_ROM, 1'b0, "R10 write not yet visible");
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(32'h0000_0000, 1'b1, S_OCR, 1'b0, "R10 write visible next cycle");
        write_ctrl(4'b0100);
        check(32'h0000_0000, 1'b1, S_ROM, 1'b0, "R10 earlier bit cleared");
        check(32'hC000_0000, 1'b1, S_WA,  1'b0, "R10 new bit set");
        repeat (3) @(negedge clk);
        check(32'hC000_0000, 1'b0, S_WA,  1'b0, "R10 value held");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_cpu_low_r2();
        t_other_low_r3();
        t_hole_r4();
        t_sdram_r5();
        t_alias_r6();
        t_windows_r7_r8();
        t_unmapped_r9();
        t_write_r10();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule